// File: doc/BRIEF.md
# Variable-Latency Test ALU with Condition Flags

This block is a 16-bit execution unit for testing the issue and writeback sequencing of a processor pipeline. It takes a request on a valid/ready input stream. The request holds two operands, an operation code, a flag that inverts operand A, and a flag that asks for a condition code. The result comes back on a valid/ready output stream. The output carries the 16-bit result and a 3-bit condition code. The condition code has its own written flag.

Add, multiply, sign-extend and shift-right go through a latency counter, and each takes a fixed number of cycles. Every other operation code computes A minus B with no delay. While the unit is idle, that result is presented in the same cycle as the request. This lets a surrounding control unit be tested under both zero-delay and multi-cycle completion.

Back-pressure rules:
- Only one operation is in flight at a time.
- `in_ready` is high only while the unit is idle.
- A result held on the output keeps `out_valid`, `result`, `cond` and `cond_ok` steady until `out_ready` is sampled high.
- A zero-delay request that meets `out_ready` low is accepted anyway. It is captured and held like any other result.

Top module: `varlat_alu`

## Requirements
- R1: After reset, `in_ready` is 1 and `out_valid` is 0.
- R2: Operation codes 4 to 7 compute A minus B, modulo 2^16. When a request with one of these codes arrives while the unit is idle, `out_valid` and `result` appear combinationally in the same cycle. With `out_ready` high, the transfer completes at that edge.
- R3: Code 0 gives A+B modulo 2^16, after 2 cycles. Code 1 gives the low 16 bits of A*B, after 4 cycles. The latency N means that `out_valid` first rises N clock edges after the accepting edge.
- R4: Code 2 sign-extends bit 7 of A over the low byte of A, after 3 cycles (0x80 gives 0xFF80, 0x7F gives 0x007F). B is ignored.
- R5: Code 3 shifts A right logically by B[3:0], after 2 cycles. The upper bits of B are ignored.
- R6: When the invert flag is set, every operation uses the bitwise complement of A in place of A.
- R7: When the condition flag is set, `cond_ok` is 1 and `cond` is one-hot. 3'b100 means the result is nonzero with bit 15 clear, 3'b010 means bit 15 is set, and 3'b001 means the result is zero.
- R8: When the condition flag is clear, `cond_ok` is 0 and `cond` is 3'b000.
- R9: While `out_valid` is high and `out_ready` is low, the next cycle keeps `out_valid` high with `result`, `cond` and `cond_ok` unchanged. A zero-delay request stalled this way is held with the value it had.
- R10: `in_ready` stays low from the acceptance of a multi-cycle operation, or of a stalled zero-delay operation, until the cycle after the result is taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Unit idle, request accepted |
| in_op | input | 3 | Operation code |
| in_a | input | 16 | Operand A |
| in_b | input | 16 | Operand B |
| in_inv_a | input | 1 | Use complement of A |
| in_want_cond | input | 1 | Produce condition code |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes result |
| result | output | 16 | Main result |
| cond | output | 3 | Condition code |
| cond_ok | output | 1 | Condition code written |

## Verification
The hardest case to reach is a zero-delay subtract that meets a stalled consumer. The unit then has to switch from its combinational pass-through to a held, registered result without losing or changing the value. The bench drives a subtract with `out_ready` low and holds it off for several cycles. It checks that `in_ready` stays low and that the value and condition fields do not move. It also times every multi-cycle code edge by edge from the accepting edge, so that an off-by-one in the counter reload shows up as a latency mismatch.

// File: rtl/varlat_alu_pkg.sv
package varlat_alu_pkg;
  localparam int OPC_W = 3;
  localparam logic [OPC_W-1:0] OPC_ADD  = 3'd0;
  localparam logic [OPC_W-1:0] OPC_MUL  = 3'd1;
  localparam logic [OPC_W-1:0] OPC_SEXT = 3'd2;
  localparam logic [OPC_W-1:0] OPC_SHR  = 3'd3;
  localparam int CC_W = 3;
  localparam logic [CC_W-1:0] CC_POS  = 3'b100;
  localparam logic [CC_W-1:0] CC_NEG  = 3'b010;
  localparam logic [CC_W-1:0] CC_ZERO = 3'b001;

  // codes with bit 2 clear go through the latency counter
  function automatic logic is_timed(input logic [OPC_W-1:0] op);
    return ~op[OPC_W-1];
  endfunction
endpackage

// File: rtl/alu_datapath.sv
module alu_datapath
  import varlat_alu_pkg::*;
#(
  parameter int W      = 16,
  parameter int BYTE_W = 8
) (
  input  logic [OPC_W-1:0] op,
  input  logic [W-1:0]     a,
  input  logic [W-1:0]     b,
  input  logic             inv_a,
  output logic [W-1:0]     res
);
  localparam int SH_W = $clog2(W);
  logic [W-1:0] a_eff;

  assign a_eff = inv_a ? ~a : a;

  always_comb begin
    unique case (op)
      OPC_ADD:  res = a_eff + b;
      OPC_MUL:  res = a_eff * b;
      OPC_SEXT: res = {{(W-BYTE_W){a_eff[BYTE_W-1]}}, a_eff[BYTE_W-1:0]};
      OPC_SHR:  res = a_eff >> b[SH_W-1:0];
      default:  res = a_eff - b;
    endcase
  end
endmodule

// File: rtl/cond_encode.sv
module cond_encode
  import varlat_alu_pkg::*;
#(
  parameter int W = 16
) (
  input  logic [W-1:0]    res,
  input  logic            en,
  output logic [CC_W-1:0] cc,
  output logic            cc_ok
);
  always_comb begin
    if (!en)                cc = '0;
    else if (res == '0)     cc = CC_ZERO;
    else if (res[W-1])      cc = CC_NEG;
    else                    cc = CC_POS;
  end
  assign cc_ok = en;
endmodule

// File: rtl/issue_sequencer.sv
module issue_sequencer
  import varlat_alu_pkg::*;
#(
  parameter int LAT_ADD  = 2,
  parameter int LAT_MUL  = 4,
  parameter int LAT_SEXT = 3,
  parameter int LAT_SHR  = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [OPC_W-1:0] in_op,
  input  logic             out_ready,
  output logic             in_ready,
  output logic             out_valid,
  output logic             live,
  output logic             capture
);
  localparam int N_TIMED = 4;
  localparam int LAT_MAX = (LAT_ADD > LAT_MUL ? LAT_ADD : LAT_MUL) > (LAT_SEXT > LAT_SHR ? LAT_SEXT : LAT_SHR)
                         ? (LAT_ADD > LAT_MUL ? LAT_ADD : LAT_MUL) : (LAT_SEXT > LAT_SHR ? LAT_SEXT : LAT_SHR);
  localparam int CNT_W = $clog2(LAT_MAX + 1);

  typedef enum logic [1:0] {S_IDLE, S_RUN, S_HOLD} seq_e;
  seq_e state;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] lat_tab [N_TIMED];
  logic             timed, take;

  generate
    for (genvar i = 0; i < N_TIMED; i++) begin : g_lat
      localparam int L = (i == 0) ? LAT_ADD : (i == 1) ? LAT_MUL : (i == 2) ? LAT_SEXT : LAT_SHR;
      assign lat_tab[i] = CNT_W'(L - 1);
    end
  endgenerate

  assign timed     = is_timed(in_op);
  assign live      = (state == S_IDLE);
  assign in_ready  = live;
  assign take      = in_valid && in_ready;
  assign out_valid = live ? (in_valid && !timed) : (state == S_HOLD);
  assign capture   = take && (timed || !out_ready);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= S_IDLE;
      cnt   <= '0;
    end else begin
      unique case (state)
        S_IDLE: if (take) begin
          if (timed) begin
            state <= S_RUN;
            cnt   <= lat_tab[in_op[1:0]];
          end else if (!out_ready) begin
            state <= S_HOLD;
          end
        end
        S_RUN: begin
          if (cnt == '0) state <= S_HOLD;
          else           cnt   <= cnt - 1'b1;
        end
        S_HOLD: if (out_ready) state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/varlat_alu.sv
module varlat_alu
  import varlat_alu_pkg::*;
#(
  parameter int W        = 16,
  parameter int BYTE_W   = 8,
  parameter int LAT_ADD  = 2,
  parameter int LAT_MUL  = 4,
  parameter int LAT_SEXT = 3,
  parameter int LAT_SHR  = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [OPC_W-1:0] in_op,
  input  logic [W-1:0]     in_a,
  input  logic [W-1:0]     in_b,
  input  logic             in_inv_a,
  input  logic             in_want_cond,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [W-1:0]     result,
  output logic [CC_W-1:0]  cond,
  output logic             cond_ok
);
  logic [W-1:0]    res_c, res_q;
  logic [CC_W-1:0] cc_c, cc_q;
  logic            ok_c, ok_q;
  logic            live, capture;

  alu_datapath #(.W(W), .BYTE_W(BYTE_W)) u_dp (
    .op(in_op), .a(in_a), .b(in_b), .inv_a(in_inv_a), .res(res_c)
  );

  cond_encode #(.W(W)) u_cc (
    .res(res_c), .en(in_want_cond), .cc(cc_c), .cc_ok(ok_c)
  );

  issue_sequencer #(
    .LAT_ADD(LAT_ADD), .LAT_MUL(LAT_MUL), .LAT_SEXT(LAT_SEXT), .LAT_SHR(LAT_SHR)
  ) u_seq (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_op(in_op),
    .out_ready(out_ready), .in_ready(in_ready), .out_valid(out_valid),
    .live(live), .capture(capture)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      res_q <= '0;
      cc_q  <= '0;
      ok_q  <= 1'b0;
    end else if (capture) begin
      res_q <= res_c;
      cc_q  <= cc_c;
      ok_q  <= ok_c;
    end
  end

  assign result  = live ? res_c : res_q;
  assign cond    = live ? cc_c  : cc_q;
  assign cond_ok = live ? ok_c  : ok_q;
endmodule

// File: rtl/varlat_alu_chk.sv
module varlat_alu_chk #(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst_n,
  input logic         in_valid,
  input logic         in_ready,
  input logic [2:0]   in_op,
  input logic         out_valid,
  input logic         out_ready,
  input logic [W-1:0] result,
  input logic [2:0]   cond,
  input logic         cond_ok
);
  assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(result) && $stable(cond) && $stable(cond_ok));

  assert_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready && !in_op[2] |=> !in_ready && !out_valid);

  assert_zero_delay_R2: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready && in_op[2] |-> out_valid);

  assert_onehot_R7: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && cond_ok |-> $countones(cond) == 1);

  assert_unwritten_R8: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !cond_ok |-> cond == 3'b000);
endmodule

bind varlat_alu varlat_alu_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .in_op(in_op), .out_valid(out_valid), .out_ready(out_ready),
  .result(result), .cond(cond), .cond_ok(cond_ok)
);

// File: tb/sim_varlat_alu.sv
module sim_varlat_alu;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0, in_ready;
  logic [2:0]  in_op = '0;
  logic [15:0] in_a = '0, in_b = '0;
  logic        in_inv_a = 1'b0, in_want_cond = 1'b0;
  logic        out_valid, out_ready = 1'b0;
  logic [15:0] result;
  logic [2:0]  cond;
  logic        cond_ok;
  int checks = 0, errors = 0;

  always #2 clk = ~clk;

  varlat_alu u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_op(in_op), .in_a(in_a), .in_b(in_b), .in_inv_a(in_inv_a),
    .in_want_cond(in_want_cond), .out_valid(out_valid), .out_ready(out_ready),
    .result(result), .cond(cond), .cond_ok(cond_ok)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // drive one request, measure latency, hold result 'stall' cycles, then drain
  task automatic run_op(input string req, input logic [2:0] op, input logic [15:0] a,
                        input logic [15:0] b, input logic inv, input logic wc,
                        input int stall, input int exp_lat, input logic [15:0] exp_res,
                        input logic [2:0] exp_cc);
    int k;
    @(negedge clk);
    in_valid = 1'b1; in_op = op; in_a = a; in_b = b; in_inv_a = inv; in_want_cond = wc;
    out_ready = 1'b0;
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0; in_op = 3'd4; in_a = 16'h1234; in_b = 16'h0001; in_inv_a = 1'b0; in_want_cond = 1'b0;
    k = 0;
    while (!out_valid && k < 20) begin
      chk({req, " R10 in_ready low in flight"}, in_ready, 0);
      @(negedge clk);
      k++;
    end
    chk({req, " latency"}, k, exp_lat);
    chk({req, " result"}, result, exp_res);
    chk({req, " cond R7/R8"}, cond, exp_cc);
    chk({req, " cond_ok R7/R8"}, cond_ok, wc);
    for (int s = 0; s < stall; s++) begin
      @(negedge clk);
      chk({req, " R9 held valid"}, out_valid, 1);
      chk({req, " R9 held result"}, result, exp_res);
      chk({req, " R9 held cond"}, cond, exp_cc);
      chk({req, " R10 in_ready low while held"}, in_ready, 0);
    end
    out_ready = 1'b1;
    @(negedge clk);
    out_ready = 1'b0;
    chk({req, " R10 drained valid"}, out_valid, 0);
    chk({req, " R10 ready again"}, in_ready, 1);
  endtask

  // zero-delay request that completes in the cycle it arrives
  task automatic run_pass(input string req, input logic [2:0] op, input logic [15:0] a,
                          input logic [15:0] b, input logic wc,
                          input logic [15:0] exp_res, input logic [2:0] exp_cc);
    @(negedge clk);
    in_valid = 1'b1; in_op = op; in_a = a; in_b = b; in_inv_a = 1'b0; in_want_cond = wc;
    out_ready = 1'b1;
    #1;
    chk({req, " R2 same-cycle valid"}, out_valid, 1);
    chk({req, " R2 result"}, result, exp_res);
    chk({req, " R7 cond"}, cond, exp_cc);
    @(negedge clk);
    in_valid = 1'b0; out_ready = 1'b0;
    #1;
    chk({req, " R2 no residue"}, out_valid, 0);
    chk({req, " R10 ready"}, in_ready, 1);
  endtask

  task automatic t_reset;
    @(negedge clk);
    chk("R1 in_ready", in_ready, 1);
    chk("R1 out_valid", out_valid, 0);
  endtask

  initial begin
    fork
      begin
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        t_reset();
        run_pass("R2 sub", 3'd4, 16'd5, 16'd2, 1'b1, 16'd3, 3'b100);
        run_pass("R2 cmp equal", 3'd5, 16'd5, 16'd5, 1'b1, 16'd0, 3'b001);
        run_op("R3 add", 3'd0, 16'd5, 16'd2, 1'b0, 1'b1, 0, 2, 16'd7, 3'b100);
        run_op("R6 inv add", 3'd0, 16'd5, 16'd2, 1'b1, 1'b1, 1, 2, 16'hFFFC, 3'b010);
        run_op("R3 mul", 3'd1, 16'd300, 16'd300, 1'b0, 1'b1, 2, 4, 16'h5F90, 3'b100);
        run_op("R4 sext neg", 3'd2, 16'h0080, 16'h0002, 1'b0, 1'b1, 0, 3, 16'hFF80, 3'b010);
        run_op("R4 sext pos", 3'd2, 16'h5A7F, 16'hFFFF, 1'b0, 1'b0, 0, 3, 16'h007F, 3'b000);
        run_op("R5 shr", 3'd3, 16'h8000, 16'h0014, 1'b0, 1'b1, 0, 2, 16'h0800, 3'b100);
        run_op("R9 stalled sub", 3'd7, 16'd2, 16'd5, 1'b0, 1'b0, 3, 0, 16'hFFFD, 3'b000);
        run_op("R7 neg sub", 3'd6, 16'd2, 16'd5, 1'b0, 1'b1, 1, 0, 16'hFFFD, 3'b010);
      end
      begin
        repeat (5000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog actual=running expected=done");
      end
    join_any
    disable fork;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule